// File: doc/BRIEF.md
# Edge-Latched Interrupt Aggregator

This block combines four external interrupt request lines into a single active-low interrupt line for a host. Every request line first passes through a two-flop synchroniser. After that, a rising-edge detector sets a sticky status bit for that source. A per-source enable register decides which latched sources may pull the shared interrupt line. A status bit stays set until the host clears it with a bitwise mask.

The host reaches the block through a small register port driven by a command decoder. Each access is a one-cycle strobe that carries a 2-bit operation code and a data byte. The four operations are:

- write the enable register
- read the enable register
- read the status register
- clear status bits under a mask

Read data comes back on a registered response port. A parameter selects one of two output styles:

- **Open drain:** the line is driven low or released.
- **Push-pull:** the line is always driven.

Top module: `irq_aggregator`

## Requirements
- R1: After reset, the enable and status registers are 0x00. The open-drain output is released (`intq_oe`=0, `intq_o`=0). The push-pull variant drives `intq_o`=1 with `intq_oe`=1.
- R2: A 0-to-1 change on `irq_in[i]`, applied between clock edges, sets status bit i exactly at the third rising clock edge afterwards. This happens whatever the enable bit is.
- R3: An input that stays high does not set its status bit again after that bit has been cleared.
- R4: A clear command (`cmd_op`=3) clears exactly the status bits whose `cmd_wdata` bit is 1. It takes effect at the clock edge that samples the command and leaves all other bits untouched.
- R5: If a rising edge and a clear of the same bit fall in the same cycle, the bit ends up set.
- R6: In open-drain mode, `intq_oe` is 1 and `intq_o` is 0 whenever any status bit and its matching enable bit are both 1. Otherwise the line is released (`intq_oe`=0).
- R7: In push-pull mode, `intq_oe` is always 1 and `intq_o` is the inverse of the interrupt condition of R6.
- R8: A write-enable command (`cmd_op`=0) loads `cmd_wdata[3:0]` into the enable register. A read-enable command (`cmd_op`=1) returns the enable register on `rsp_data`, with `rsp_valid` high for exactly the one cycle after the command edge. Bits 7:4 always read 0.
- R9: A read-status command (`cmd_op`=2) returns the status register in bits 3:0, with bits 7:4 reading 0, using the same one-cycle response timing as R8.
- R10: A status bit latched while its enable bit was 0 asserts the output in the cycle right after the enable bit is written to 1.
- R11: A 1-to-0 change on an input never sets a status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 4 | Asynchronous interrupt request lines |
| cmd_valid | input | 1 | One-cycle command strobe |
| cmd_op | input | 2 | Operation: 0 write enable, 1 read enable, 2 read status, 3 clear status |
| cmd_wdata | input | 8 | Enable value or clear mask |
| rsp_valid | output | 1 | Read data valid, one cycle |
| rsp_data | output | 8 | Read data, bits 7:4 zero |
| intq_o | output | 1 | Interrupt line drive value (active low) |
| intq_oe | output | 1 | Interrupt line drive enable |

## Verification
The bench changes every input half a cycle before a rising edge. It then samples on falling edges, which places each expected value on an exact count of edges:

- **Input edge to status and output:** a rising input shows in status and on the interrupt line three edges later. The bench checks that the line is still quiet after two edges and active after the third.
- **Register commands:** a command acts on the first edge after it is driven. Read responses, enable changes and clears are therefore observed at the very next falling edge.
- **Set-wins case:** the clear is placed on the third edge after a rising input, so that it lands in the same cycle as the detected edge.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;

    // Command operation codes on the register port
    typedef enum logic [1:0] {
        OP_EN_WR  = 2'd0,
        OP_EN_RD  = 2'd1,
        OP_ST_RD  = 2'd2,
        OP_ST_CLR = 2'd3
    } irq_op_e;

endpackage

// File: rtl/irqagg_sync_edge.sv
module irqagg_sync_edge #(
    parameter int NUM_SRC     = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] raw_in,
    output logic [NUM_SRC-1:0] rise_pulse
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [NUM_SRC-1:0] stage_q [SYNC_STAGES];
    logic [NUM_SRC-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < SYNC_STAGES; k++) begin
                stage_q[k] <= '0;
            end
            prev_q <= '0;
        end else begin
            stage_q[0] <= raw_in;
            for (int k = 1; k < SYNC_STAGES; k++) begin
                stage_q[k] <= stage_q[k-1];
            end
            prev_q <= stage_q[LAST];
        end
    end

    // Only a low-to-high change of the synchronised level counts
    assign rise_pulse = stage_q[LAST] & ~prev_q;

endmodule

// File: rtl/irqagg_regs.sv
module irqagg_regs
    import irqagg_pkg::*;
#(
    parameter int NUM_SRC = 4,
    parameter int REG_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] rise_pulse,
    input  logic               cmd_valid,
    input  logic [1:0]         cmd_op,
    input  logic [REG_W-1:0]   cmd_wdata,
    output logic               rsp_valid,
    output logic [REG_W-1:0]   rsp_data,
    output logic [NUM_SRC-1:0] enable_q,
    output logic [NUM_SRC-1:0] status_q
);
    irq_op_e            op;
    logic [NUM_SRC-1:0] clr_mask;
    logic [REG_W-1:0]   rd_word;
    logic               is_read;
    logic               wdata_unused;

    assign op           = irq_op_e'(cmd_op);
    assign wdata_unused = ^cmd_wdata[REG_W-1:NUM_SRC];
    assign is_read      = cmd_valid && (op == OP_EN_RD || op == OP_ST_RD);
    assign clr_mask     = (cmd_valid && op == OP_ST_CLR) ? cmd_wdata[NUM_SRC-1:0] : '0;

    always_comb begin
        rd_word = '0;
        if (op == OP_EN_RD) begin
            rd_word[NUM_SRC-1:0] = enable_q;
        end else begin
            rd_word[NUM_SRC-1:0] = status_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            enable_q  <= '0;
            status_q  <= '0;
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            if (cmd_valid && op == OP_EN_WR) begin
                enable_q <= cmd_wdata[NUM_SRC-1:0];
            end
            // A fresh edge overrides a clear in the same cycle
            status_q  <= (status_q & ~clr_mask) | rise_pulse;
            rsp_valid <= is_read;
            rsp_data  <= is_read ? rd_word : '0;
        end
    end

endmodule

// File: rtl/irqagg_drive.sv
module irqagg_drive #(
    parameter bit OPEN_DRAIN = 1'b1
) (
    input  logic active,
    output logic line_o,
    output logic line_oe
);
    generate
        if (OPEN_DRAIN) begin : g_od
            assign line_o  = 1'b0;
            assign line_oe = active;
        end else begin : g_pp
            assign line_o  = ~active;
            assign line_oe = 1'b1;
        end
    endgenerate
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator #(
    parameter int NUM_SRC     = 4,
    parameter int REG_W       = 8,
    parameter int SYNC_STAGES = 2,
    parameter bit OPEN_DRAIN  = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_in,
    input  logic               cmd_valid,
    input  logic [1:0]         cmd_op,
    input  logic [REG_W-1:0]   cmd_wdata,
    output logic               rsp_valid,
    output logic [REG_W-1:0]   rsp_data,
    output logic               intq_o,
    output logic               intq_oe
);
    logic [NUM_SRC-1:0] rise_pulse;
    logic [NUM_SRC-1:0] enable_q;
    logic [NUM_SRC-1:0] status_q;
    logic               irq_active;

    irqagg_sync_edge #(.NUM_SRC(NUM_SRC), .SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .raw_in     (irq_in),
        .rise_pulse (rise_pulse)
    );

    irqagg_regs #(.NUM_SRC(NUM_SRC), .REG_W(REG_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .rise_pulse (rise_pulse),
        .cmd_valid  (cmd_valid),
        .cmd_op     (cmd_op),
        .cmd_wdata  (cmd_wdata),
        .rsp_valid  (rsp_valid),
        .rsp_data   (rsp_data),
        .enable_q   (enable_q),
        .status_q   (status_q)
    );

    assign irq_active = |(status_q & enable_q);

    irqagg_drive #(.OPEN_DRAIN(OPEN_DRAIN)) u_drive (
        .active  (irq_active),
        .line_o  (intq_o),
        .line_oe (intq_oe)
    );

endmodule

// File: rtl/irqagg_chk.sv
module irqagg_chk
    import irqagg_pkg::*;
#(
    parameter int NUM_SRC = 4,
    parameter int REG_W   = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cmd_valid,
    input logic [1:0]         cmd_op,
    input logic [REG_W-1:0]   cmd_wdata,
    input logic               rsp_valid,
    input logic [REG_W-1:0]   rsp_data,
    input logic [NUM_SRC-1:0] status_q,
    input logic [NUM_SRC-1:0] rise_pulse
);
    // R4
    clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_ST_CLR) |=>
        ((status_q & $past(cmd_wdata[NUM_SRC-1:0] & ~rise_pulse)) == '0));

    // R5
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|rise_pulse) |=> ((status_q & $past(rise_pulse)) == $past(rise_pulse)));

    // R11
    set_only_by_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_q & ~$past(status_q) & ~$past(rise_pulse)) == '0));

    // R8
    rsp_follows_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && (cmd_op == OP_EN_RD || cmd_op == OP_ST_RD)) |=> rsp_valid);

    // R8
    rsp_only_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_valid && (cmd_op == OP_EN_RD || cmd_op == OP_ST_RD)) |=> !rsp_valid);

    // R9
    rsp_reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_data[REG_W-1:NUM_SRC] == '0));

endmodule

bind irq_aggregator irqagg_chk #(.NUM_SRC(NUM_SRC), .REG_W(REG_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_op     (cmd_op),
    .cmd_wdata  (cmd_wdata),
    .rsp_valid  (rsp_valid),
    .rsp_data   (rsp_data),
    .status_q   (status_q),
    .rise_pulse (rise_pulse)
);

// File: tb/irq_aggregator_bench.sv
module irq_aggregator_bench;
    localparam time HALF = 2.5ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] irq_in = '0;
    logic       cmd_valid = 1'b0;
    logic [1:0] cmd_op = '0;
    logic [7:0] cmd_wdata = '0;
    logic       rsp_valid, rsp_valid_pp;
    logic [7:0] rsp_data, rsp_data_pp;
    logic       intq_o, intq_oe, pp_o, pp_oe;

    int total = 0;
    int bad   = 0;

    always #(HALF) clk = ~clk;

    irq_aggregator u_irq_aggregator (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .cmd_valid(cmd_valid),
        .cmd_op(cmd_op), .cmd_wdata(cmd_wdata), .rsp_valid(rsp_valid),
        .rsp_data(rsp_data), .intq_o(intq_o), .intq_oe(intq_oe)
    );

    irq_aggregator #(.OPEN_DRAIN(1'b0)) u_irq_aggregator_pp (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .cmd_valid(cmd_valid),
        .cmd_op(cmd_op), .cmd_wdata(cmd_wdata), .rsp_valid(rsp_valid_pp),
        .rsp_data(rsp_data_pp), .intq_o(pp_o), .intq_oe(pp_oe)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Drive a command on a falling edge; it is sampled by the next rising edge
    task automatic do_cmd(input logic [1:0] op, input logic [7:0] d);
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_wdata = d;
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_wdata = '0;
    endtask

    task automatic rd(input string req, input logic [1:0] op, input logic [7:0] exp);
        do_cmd(op, 8'h00);
        chk({req, " rsp_valid"}, rsp_valid, 1'b1);
        chk({req, " rsp_data"}, rsp_data, exp);
    endtask

    task automatic t_reset;
        wait_cyc(1);
        chk("R1 oe", intq_oe, 1'b0);
        chk("R1 o", intq_o, 1'b0);
        chk("R1 pp o", pp_o, 1'b1);
        chk("R1 pp oe", pp_oe, 1'b1);
        rd("R1 enable", 2'd1, 8'h00);
        rd("R1 status", 2'd2, 8'h00);
    endtask

    task automatic t_readback;
        do_cmd(2'd0, 8'hFF);
        rd("R8 enable readback", 2'd1, 8'h0F);
        wait_cyc(1);
        chk("R8 rsp_valid single cycle", rsp_valid, 1'b0);
        do_cmd(2'd0, 8'h00);
    endtask

    task automatic t_rise;
        do_cmd(2'd0, 8'h01);
        irq_in[0] = 1'b1;
        wait_cyc(2);
        chk("R2 not yet at edge 2", intq_oe, 1'b0);
        wait_cyc(1);
        chk("R2 R6 asserted at edge 3", intq_oe, 1'b1);
        chk("R6 drive low", intq_o, 1'b0);
        chk("R7 pp low", pp_o, 1'b0);
        chk("R7 pp oe", pp_oe, 1'b1);
        rd("R9 status", 2'd2, 8'h01);
    endtask

    task automatic t_clear_mask;
        irq_in[2:1] = 2'b11;
        wait_cyc(3);
        rd("R2 disabled sources latch", 2'd2, 8'h07);
        do_cmd(2'd3, 8'hF5);
        chk("R6 released after clear", intq_oe, 1'b0);
        rd("R4 masked clear", 2'd2, 8'h02);
        wait_cyc(4);
        rd("R3 held level no reset", 2'd2, 8'h02);
    endtask

    task automatic t_fall;
        do_cmd(2'd3, 8'h0F);
        irq_in = 4'b0000;
        wait_cyc(4);
        rd("R11 falling ignored", 2'd2, 8'h00);
    endtask

    task automatic t_enable_late;
        irq_in[3] = 1'b1;
        wait_cyc(3);
        chk("R10 quiet while disabled", intq_oe, 1'b0);
        rd("R10 latched while disabled", 2'd2, 8'h08);
        do_cmd(2'd0, 8'h08);
        chk("R10 asserted after enable", intq_oe, 1'b1);
        chk("R7 pp after enable", pp_o, 1'b0);
        do_cmd(2'd3, 8'h08);
        chk("R6 released", intq_oe, 1'b0);
        chk("R7 pp released", pp_o, 1'b1);
        irq_in[3] = 1'b0;
        wait_cyc(3);
    endtask

    task automatic t_set_wins;
        irq_in[1] = 1'b1;
        wait_cyc(3);
        rd("R5 preset bit1", 2'd2, 8'h02);
        irq_in[2] = 1'b1;
        wait_cyc(2);
        do_cmd(2'd3, 8'h06);
        rd("R5 set wins bit2, bit1 cleared", 2'd2, 8'h04);
    endtask

    initial begin
        #(HALF * 2 * 200000);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        wait_cyc(3);
        rst_n = 1'b1;
        t_reset();
        t_readback();
        t_rise();
        t_clear_mask();
        t_fall();
        t_enable_late();
        t_set_wins();
        wait_cyc(2);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule